// File: doc/BRIEF.md
# Power status flag register

This block keeps a record of the wake-up and low-power-mode entry events that a power controller reports. Six external wake-up pin channels and a group of internal wake-up sources feed it. The pin channels arrive as single-cycle pulses, and each pulse sets a sticky flag. The internal sources arrive as levels, and their OR is shown as one flag that software cannot clear. Two strobes report entry into Standby and into one of three Stop levels. These strobes update a standby flag and a 3-bit stop code.

Software reads the whole status word from a read port that is always valid. It clears flags by writing ones to a separate clear register, which cannot be read. The block has two active-low asynchronous resets. Power-on reset clears every flag. System reset clears the wake flags and the internal flag, but it leaves the standby flag and the stop code unchanged. This lets software find out, after a reset, which low-power mode the device left.

Top module: `pwr_flag_reg`

## Requirements
- R1: A one-cycle pulse on wakePin[i] sets status bit i, which reads 1 on rdData from the cycle after the pulse. The bit map is bits 0 to 4 for pins 1 to 5 and bit 5 for pin 7. There is no flag for pin 6.
- R2: A write with wrAddr = 1 (the clear register) and wrData[i] = 1 clears wake flag i for i in 0..5 on the next edge. Zero bits in the write data leave their flags unchanged.
- R3: When a pin pulse and a clear write hit the same wake flag in the same cycle, the flag is 1 afterwards.
- R4: A standbyEnter pulse sets the standby flag at status bit 8 on the next edge.
- R5: A stopEnter pulse with stopLevel 0, 1 or 2 loads code 4, 5 or 6 into status bits 11:9. The latest entry replaces the earlier one. A stopEnter pulse with stopLevel 3 changes nothing. The field only ever reads 0, 4, 5 or 6.
- R6: A clear write with wrData[8] = 1 clears both the standby flag and the stop code. A mode entry in the same cycle wins for the flag or field it sets.
- R7: Asserting sysRstN clears the wake flags and the internal flag but keeps the standby flag and the stop code. Asserting porRstN clears every flag.
- R8: Status bit 15 reads the OR of intWakeSrc as sampled at the previous edge. It falls on its own once all sources are low, and clear writes do not affect it.
- R9: Writes with wrAddr = 0 (the status word) change no flag. Status bits 7:6, 14:12 and 31:16 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| sysRstN | input | 1 | System reset, active low, asynchronous; clears wake and internal flags |
| wakePin | input | 6 | Wake-up event pulses, pins 1..5 and 7 |
| intWakeSrc | input | NUM_INT_SRC (4) | Internal wake-up source levels |
| standbyEnter | input | 1 | Standby entry strobe |
| stopEnter | input | 1 | Stop entry strobe |
| stopLevel | input | 2 | Stop level entered (0, 1, 2) |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 1 | 0 = status word, 1 = clear register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Status word |

## Verification
Software clearing and hardware setting can land on the same flag in the same cycle. This can happen for a wake pin, for the standby flag, and for the stop code. The bench provokes the collision with directed cycles that carry a pin pulse or a mode strobe together with a clear write of all ones. Long random runs then repeat it at a high rate. In each case the read word after the edge must show the flag set, or the new stop code. A reference model built from the requirements supplies that value, and the collisions also exercise the system-reset survival of the mode flags.

// File: rtl/pwr_flag_pkg.sv
package pwr_flag_pkg;
  localparam int NUM_PINS    = 6;
  localparam int DATA_W      = 32;
  localparam int STOP_W      = 3;
  localparam int LEVEL_W     = 2;
  localparam int WAKE_LSB    = 0;
  localparam int STANDBY_BIT = 8;
  localparam int STOP_LSB    = 9;
  localparam int INT_BIT     = 15;
  localparam int CLR_MODE_BIT = 8;
  localparam logic ADDR_CLEAR = 1'b1;
  localparam logic [STOP_W-1:0] STOP_BASE = 3'd4;
  localparam logic [LEVEL_W-1:0] LEVEL_MAX = 2'd2;

  typedef struct packed {
    logic [NUM_PINS-1:0] setWake;
    logic [NUM_PINS-1:0] clrWake;
    logic                setStandby;
    logic                setStop;
    logic [STOP_W-1:0]   stopCode;
    logic                clrMode;
  } flagStrobes_t;
endpackage

// File: rtl/pwr_flag_ctrl.sv
module pwr_flag_ctrl
  import pwr_flag_pkg::*;
(
  input  logic [NUM_PINS-1:0] wakePin,
  input  logic                standbyEnter,
  input  logic                stopEnter,
  input  logic [LEVEL_W-1:0]  stopLevel,
  input  logic                wrEn,
  input  logic                wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  output flagStrobes_t        strobes
);
  logic clrWrite;
  logic levelOk;

  always_comb begin
    clrWrite = wrEn && (wrAddr == ADDR_CLEAR);
    levelOk  = (stopLevel <= LEVEL_MAX);
    strobes.setWake    = wakePin;
    strobes.clrWake    = clrWrite ? wrData[WAKE_LSB +: NUM_PINS] : '0;
    strobes.setStandby = standbyEnter;
    strobes.setStop    = stopEnter && levelOk;
    strobes.stopCode   = STOP_BASE + {{(STOP_W-LEVEL_W){1'b0}}, stopLevel};
    strobes.clrMode    = clrWrite && wrData[CLR_MODE_BIT];
  end
endmodule

// File: rtl/pwr_flag_dp.sv
module pwr_flag_dp
  import pwr_flag_pkg::*;
#(
  parameter int NUM_INT_SRC = 4
) (
  input  logic                   clk,
  input  logic                   porRstN,
  input  logic                   sysRstN,
  input  flagStrobes_t           strobes,
  input  logic [NUM_INT_SRC-1:0] intWakeSrc,
  output logic [DATA_W-1:0]      statusWord
);
  logic                wakeRstN;
  logic [NUM_PINS-1:0] wakeFlag;
  logic                standbyFlag;
  logic [STOP_W-1:0]   stopCode;
  logic                intFlag;

  assign wakeRstN = porRstN & sysRstN;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_wake
    always_ff @(posedge clk or negedge wakeRstN) begin
      if (!wakeRstN)                 wakeFlag[i] <= 1'b0;
      else if (strobes.setWake[i])   wakeFlag[i] <= 1'b1;
      else if (strobes.clrWake[i])   wakeFlag[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      standbyFlag <= 1'b0;
      stopCode    <= '0;
    end else begin
      if (strobes.setStandby)     standbyFlag <= 1'b1;
      else if (strobes.clrMode)   standbyFlag <= 1'b0;
      if (strobes.setStop)        stopCode <= strobes.stopCode;
      else if (strobes.clrMode)   stopCode <= '0;
    end
  end

  always_ff @(posedge clk or negedge wakeRstN) begin
    if (!wakeRstN) intFlag <= 1'b0;
    else           intFlag <= |intWakeSrc;
  end

  always_comb begin
    statusWord = '0;
    statusWord[WAKE_LSB +: NUM_PINS] = wakeFlag;
    statusWord[STANDBY_BIT]          = standbyFlag;
    statusWord[STOP_LSB +: STOP_W]   = stopCode;
    statusWord[INT_BIT]              = intFlag;
  end
endmodule

// File: rtl/pwr_flag_reg.sv
module pwr_flag_reg
  import pwr_flag_pkg::*;
#(
  parameter int NUM_INT_SRC = 4
) (
  input  logic                   clk,
  input  logic                   porRstN,
  input  logic                   sysRstN,
  input  logic [NUM_PINS-1:0]    wakePin,
  input  logic [NUM_INT_SRC-1:0] intWakeSrc,
  input  logic                   standbyEnter,
  input  logic                   stopEnter,
  input  logic [LEVEL_W-1:0]     stopLevel,
  input  logic                   wrEn,
  input  logic                   wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData
);
  flagStrobes_t strobes;

  pwr_flag_ctrl u_ctrl (
    .wakePin(wakePin), .standbyEnter(standbyEnter), .stopEnter(stopEnter),
    .stopLevel(stopLevel), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobes(strobes)
  );

  pwr_flag_dp #(.NUM_INT_SRC(NUM_INT_SRC)) u_dp (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .strobes(strobes),
    .intWakeSrc(intWakeSrc), .statusWord(rdData)
  );
endmodule

// File: rtl/pwr_flag_chk.sv
module pwr_flag_chk
  import pwr_flag_pkg::*;
#(
  parameter int NUM_INT_SRC = 4
) (
  input logic                   clk,
  input logic                   porRstN,
  input logic                   sysRstN,
  input logic [NUM_PINS-1:0]    wakePin,
  input logic [NUM_INT_SRC-1:0] intWakeSrc,
  input logic                   standbyEnter,
  input logic                   wrEn,
  input logic                   wrAddr,
  input logic [DATA_W-1:0]      wrData,
  input logic [DATA_W-1:0]      rdData
);
  logic allRstN;
  logic armed;
  logic clrHit;
  logic [NUM_PINS-1:0] clrMask;
  logic [STOP_W-1:0] stopNow;

  assign allRstN = porRstN & sysRstN;
  assign clrHit  = wrEn && (wrAddr == ADDR_CLEAR);
  assign clrMask = clrHit ? wrData[WAKE_LSB +: NUM_PINS] : '0;
  assign stopNow = rdData[STOP_LSB +: STOP_W];

  always_ff @(posedge clk or negedge allRstN) begin
    if (!allRstN) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  // R1 R3
  wake_set_chk: assert property (@(posedge clk) disable iff (!allRstN)
    armed |=> ((rdData[WAKE_LSB +: NUM_PINS] & $past(wakePin)) == $past(wakePin)));

  // R2
  wake_clr_chk: assert property (@(posedge clk) disable iff (!allRstN)
    armed |=> ((rdData[WAKE_LSB +: NUM_PINS] & $past(clrMask & ~wakePin)) == '0));

  // R2
  wake_hold_chk: assert property (@(posedge clk) disable iff (!allRstN)
    (armed && !clrHit && wakePin == '0) |=> $stable(rdData[WAKE_LSB +: NUM_PINS]));

  // R4
  standby_set_chk: assert property (@(posedge clk) disable iff (!allRstN)
    (armed && standbyEnter) |=> rdData[STANDBY_BIT]);

  // R8
  int_flag_chk: assert property (@(posedge clk) disable iff (!allRstN)
    armed |=> (rdData[INT_BIT] == $past(|intWakeSrc)));

  // R5 R9
  always_comb begin
    if (porRstN) begin
      stop_code_legal_chk: assert (stopNow == 3'd0 || stopNow == 3'd4 ||
                                   stopNow == 3'd5 || stopNow == 3'd6);
      reserved_zero_chk: assert (rdData[7:6] == 2'b0 && rdData[14:12] == 3'b0 &&
                                 rdData[31:16] == 16'b0);
    end
  end
endmodule

bind pwr_flag_reg pwr_flag_chk #(.NUM_INT_SRC(NUM_INT_SRC)) u_chk (
  .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .wakePin(wakePin),
  .intWakeSrc(intWakeSrc), .standbyEnter(standbyEnter), .wrEn(wrEn),
  .wrAddr(wrAddr), .wrData(wrData), .rdData(rdData)
);

// File: tb/pwr_flag_reg_tb.sv
module pwr_flag_reg_tb;
  logic clk = 1'b0;
  logic porRstN = 1'b0, sysRstN = 1'b1;
  logic [5:0] wakePin = '0;
  logic [3:0] intWakeSrc = '0;
  logic standbyEnter = 1'b0, stopEnter = 1'b0;
  logic [1:0] stopLevel = '0;
  logic wrEn = 1'b0, wrAddr = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  logic [5:0] mWake = '0;
  logic mStandby = 1'b0;
  logic [2:0] mStop = '0;
  logic mInt = 1'b0;

  always #5 clk = ~clk;

  pwr_flag_reg u_dut (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .wakePin(wakePin),
    .intWakeSrc(intWakeSrc), .standbyEnter(standbyEnter), .stopEnter(stopEnter),
    .stopLevel(stopLevel), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdData(rdData)
  );

  function automatic logic [31:0] expWord();
    logic [31:0] w = '0;
    w[5:0] = mWake; w[8] = mStandby; w[11:9] = mStop; w[15] = mInt;
    return w;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    logic [31:0] e = expWord();
    check({tag, " wake"}, {26'b0, rdData[5:0]}, {26'b0, e[5:0]});
    check({tag, " mode"}, {20'b0, rdData[11:8]}, {20'b0, e[11:8]});
    check({tag, " int"}, {31'b0, rdData[15]}, {31'b0, e[15]});
    check({tag, " R9 reserved"}, rdData & 32'hFFFF_70C0, 32'h0);
  endtask

  // drive at negedge, one posedge, update model, compare at next negedge
  task automatic cycle(string tag, logic [5:0] p, logic sb, logic st, logic [1:0] lv,
                       logic we, logic ad, logic [31:0] d, logic [3:0] src);
    wakePin = p; standbyEnter = sb; stopEnter = st; stopLevel = lv;
    wrEn = we; wrAddr = ad; wrData = d; intWakeSrc = src;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      if (p[i]) mWake[i] = 1'b1;
      else if (we && ad && d[i]) mWake[i] = 1'b0;
    end
    if (sb) mStandby = 1'b1;
    else if (we && ad && d[8]) mStandby = 1'b0;
    if (st && lv != 2'd3) mStop = 3'd4 + {1'b0, lv};
    else if (we && ad && d[8]) mStop = 3'd0;
    mInt = |src;
    checkAll(tag);
  endtask

  task automatic idleInputs();
    wakePin = '0; standbyEnter = 0; stopEnter = 0; wrEn = 0; intWakeSrc = '0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R7 por reset state", rdData, 32'h0);
    porRstN = 1'b1;
    @(negedge clk);
    checkAll("R7 after por release");

    cycle("R1 pin1 set", 6'b000001, 0, 0, 0, 0, 0, 0, 0);
    cycle("R1 pin7 set", 6'b100000, 0, 0, 0, 0, 0, 0, 0);
    check("R1 bit5 is pin7", {31'b0, rdData[5]}, 32'd1);
    cycle("R2 zero write keeps", 0, 0, 0, 0, 1, 1, 32'h0, 0);
    cycle("R2 clear pin1", 0, 0, 0, 0, 1, 1, 32'h1, 0);
    check("R2 pin7 kept", {31'b0, rdData[5]}, 32'd1);
    cycle("R3 set beats clear", 6'b100000, 0, 0, 0, 1, 1, 32'hFFFF_FFFF, 0);
    check("R3 pin7 still set", {31'b0, rdData[5]}, 32'd1);
    cycle("R9 status write ignored", 0, 0, 0, 0, 1, 0, 32'hFFFF_FFFF, 0);
    check("R9 word unchanged", rdData, 32'h0000_0020);
    cycle("R4 standby set", 0, 1, 0, 0, 0, 0, 0, 0);
    cycle("R5 stop level1", 0, 0, 1, 2'd1, 0, 0, 0, 0);
    check("R5 code 5", {29'b0, rdData[11:9]}, 32'd5);
    cycle("R5 stop level2 replaces", 0, 0, 1, 2'd2, 0, 0, 0, 0);
    cycle("R5 level3 ignored", 0, 0, 1, 2'd3, 0, 0, 0, 0);
    check("R5 code stays 6", {29'b0, rdData[11:9]}, 32'd6);
    cycle("R8 int source on", 0, 0, 0, 0, 0, 0, 0, 4'b0100);
    cycle("R8 clear write no effect", 0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF, 4'b0100);
    check("R8 int stays", {31'b0, rdData[15]}, 32'd1);
    cycle("R4 R6 standby set", 0, 1, 1, 2'd0, 0, 0, 0, 0);
    cycle("R6 set beats clear", 0, 1, 1, 2'd1, 1, 1, 32'h100, 0);
    check("R6 standby kept", {31'b0, rdData[8]}, 32'd1);
    check("R6 new stop code", {29'b0, rdData[11:9]}, 32'd5);

    // R7 system reset keeps mode flags
    cycle("R7 setup", 6'b011011, 0, 0, 0, 0, 0, 0, 4'b0001);
    idleInputs();
    sysRstN = 1'b0;
    #2;
    mWake = '0; mInt = 1'b0;
    checkAll("R7 during sys reset");
    @(negedge clk);
    sysRstN = 1'b1;
    checkAll("R7 after sys reset");
    check("R7 mode survives", {20'b0, rdData[11:8]}, 32'hB);
    cycle("R6 clear mode", 0, 0, 0, 0, 1, 1, 32'h100, 0);
    check("R6 mode cleared", {20'b0, rdData[11:8]}, 32'h0);

    // random mix, clear writes and events frequent to provoke collisions
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] p;
      logic [31:0] d;
      p = 6'($urandom) & 6'($urandom) & 6'($urandom);
      d = $urandom;
      cycle("R1/R2/R3/R4/R5/R6/R8 random", p, ($urandom % 8) == 0, ($urandom % 6) == 0,
            2'($urandom), ($urandom % 3) == 0, 1'($urandom), d, 4'($urandom) & 4'($urandom));
      if (n == 1500) begin
        idleInputs();
        sysRstN = 1'b0;
        #2; mWake = '0; mInt = 1'b0;
        @(negedge clk);
        sysRstN = 1'b1;
        checkAll("R7 random sys reset");
      end
    end

    cycle("R7 pre por", 6'b111111, 1, 1, 2'd0, 0, 0, 0, 4'hF);
    idleInputs();
    porRstN = 1'b0;
    #2;
    check("R7 por clears all", rdData, 32'h0);
    mWake = '0; mStandby = 0; mStop = '0; mInt = 0;
    @(negedge clk);
    porRstN = 1'b1;
    checkAll("R7 after por");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule